// File: doc/BRIEF.md
# SYSREF Multiframe Alignment Monitor

This block keeps a local multiframe (or extended multiblock) counter in step with a periodic SYSREF reference. The counter runs at the device clock and wraps every `period_clks` cycles, raising a one-clock boundary strobe at each wrap. When both the alignment enable and the system enable are high, the first SYSREF pulse sets the counter phase. Each later pulse is compared with the counter boundary.

The aligned flag goes high only after a second pulse lands on the boundary set by an earlier pulse. A pulse that lands off the boundary moves the counter phase to that pulse, and confirmation starts again. The block counts the pulses it accepts. If fifteen pulses arrive without a confirmation, it raises an acquisition-timeout flag and keeps trying. The flags are visible only on output ports and cannot be cleared except by dropping an enable.

Top module: `sysref_align_mon`

## Requirements
- R1: During and after reset, with both enables low, `mf_strobe`, `aligned`, `acq_timeout` and `pulse_cnt` are all 0.
- R2: While `align_en` or `sys_en` is low, SYSREF pulses have no effect: `pulse_cnt` stays 0, `aligned` stays 0 and `mf_strobe` never rises.
- R3: While enabled, `mf_strobe` is high for exactly one clock every P clocks. P is `period_clks` limited to the range 4 to 1024: values below 4 act as 4, and values above 1024 act as 1024.
- R4: The first accepted pulse restarts the counter. Take the clock edge that first samples `sysref_in` high as edge 1. The next `mf_strobe` is low after edge P+1, high after edge P+2, and low again after edge P+3. The delay comes from a two-flop synchroniser plus an edge register.
- R5: A pulse whose rising edge comes a whole multiple of P clocks after the phase-setting pulse sets `aligned`. `aligned` is never high while `pulse_cnt` is below 2.
- R6: A confirming pulse off the boundary leaves `aligned` low and becomes the new phase reference. A later pulse a multiple of P clocks after it then sets `aligned`.
- R7: While aligned, an off-boundary pulse clears `aligned` and becomes the new phase reference. The next on-boundary pulse sets `aligned` again.
- R8: A SYSREF pulse held high for many clocks is accepted once, so `pulse_cnt` rises by exactly one.
- R9: `pulse_cnt` (5 bits) counts accepted pulses since enable and saturates at 31.
- R10: `acq_timeout` rises on the fifteenth accepted pulse if `aligned` has not yet been reached, and stays low after fourteen. Acquisition continues after a timeout: a later on-boundary pulse still sets `aligned`, and `acq_timeout` stays high.
- R11: Dropping either enable clears `aligned`, `acq_timeout`, `pulse_cnt` and `mf_strobe` by the next clock edge.
- R12: On-boundary pulses keep `aligned` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| sysref_in | input | 1 | SYSREF after sampling, asynchronous to clk |
| period_clks | input | 11 | Multiframe period in clocks, limited to 4..1024 |
| align_en | input | 1 | SYSREF alignment enable |
| sys_en | input | 1 | System enable |
| mf_strobe | output | 1 | One-clock strobe at each counter wrap |
| aligned | output | 1 | Phase set and confirmed |
| acq_timeout | output | 1 | Fifteen pulses accepted without confirmation |
| pulse_cnt | output | 5 | Accepted pulses since enable, saturating |

## Verification
The hardest case to reach is the acquisition timeout followed by a late lock. To get there, the bench must keep every pulse off the boundary for fourteen pulses and then land exactly on it. Each pulse moves the phase, so the bench spaces pulses P+1 clocks apart: every pulse then misses the boundary set by the one before it. It then shortens a single gap to exactly P to confirm. Pulse spacing is counted in whole clocks from each driven rising edge, so the expected outcome does not depend on the synchroniser latency.

// File: rtl/sra_pkg.sv
package sra_pkg;

    // Acquisition state of the alignment monitor
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_SEEK    = 2'd1,
        ST_CONFIRM = 2'd2,
        ST_LOCK    = 2'd3
    } sra_state_e;

endpackage

// File: rtl/sra_sysref_edge.sv
module sra_sysref_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sysref_in,
    output logic event_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], sysref_in};
        st_d.last = st_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign event_o = st_q.sync[SYNC_STAGES-1] & ~st_q.last;

    AST_ONE_EVENT_PER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> !event_o); // R8

endmodule

// File: rtl/sra_mf_counter.sv
module sra_mf_counter #(
    parameter int PER_W = 11,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             realign,
    input  logic [PER_W-1:0] period,
    output logic             wrap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    at_last;

    always_comb begin
        at_last = (PER_W'(st_q.cnt) >= (period - PER_W'(1)));
        st_d    = st_q;
        if (!enable)
            st_d.cnt = '0;
        else if (realign || at_last)
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wrap_o = enable & at_last;

    AST_STROBE_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && $stable(period)) |=> !wrap_o); // R3

    AST_REALIGN_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && realign) |=> (st_q.cnt == '0)); // R4

    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !wrap_o); // R2

endmodule

// File: rtl/sra_align_fsm.sv
module sra_align_fsm
    import sra_pkg::*;
#(
    parameter int PCNT_W  = 5,
    parameter int MAX_ACQ = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sysref_ev,
    input  logic              on_boundary,
    output logic              realign,
    output logic              aligned,
    output logic              acq_timeout,
    output logic [PCNT_W-1:0] pulse_cnt
);

    typedef struct packed {
        sra_state_e        state;
        logic [PCNT_W-1:0] pcnt;
        logic              timeout;
        logic              seen_lock;
    } fsm_st_t;

    fsm_st_t st_d, st_q;
    logic    ev;

    always_comb begin
        ev   = enable & sysref_ev;
        st_d = st_q;
        if (!enable) begin
            st_d = '0;
        end else begin
            if (st_q.state == ST_OFF)
                st_d.state = ST_SEEK;
            if (ev) begin
                if (st_q.pcnt != '1)
                    st_d.pcnt = st_q.pcnt + PCNT_W'(1);
                case (st_q.state)
                    ST_OFF, ST_SEEK: st_d.state = ST_CONFIRM;
                    ST_CONFIRM:      st_d.state = on_boundary ? ST_LOCK : ST_CONFIRM;
                    ST_LOCK:         st_d.state = on_boundary ? ST_LOCK : ST_CONFIRM;
                    default:         st_d.state = ST_SEEK;
                endcase
                if (st_d.state == ST_LOCK)
                    st_d.seen_lock = 1'b1;
                else if (!st_q.seen_lock && (int'(st_d.pcnt) >= MAX_ACQ))
                    st_d.timeout = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign realign     = ev;
    assign aligned     = (st_q.state == ST_LOCK);
    assign acq_timeout = st_q.timeout;
    assign pulse_cnt   = st_q.pcnt;

    AST_LOCK_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        aligned |-> (int'(pulse_cnt) >= 2)); // R5

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!aligned && !acq_timeout && pulse_cnt == '0)); // R11

    AST_TIMEOUT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acq_timeout) |-> ((int'(pulse_cnt) >= MAX_ACQ) && !aligned)); // R10

    AST_COUNT_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !sysref_ev) |=> $stable(pulse_cnt)); // R8

endmodule

// File: rtl/sysref_align_mon.sv
module sysref_align_mon #(
    parameter int PERIOD_MIN  = 4,
    parameter int PERIOD_MAX  = 1024,
    parameter int PER_W       = 11,
    parameter int SYNC_STAGES = 2,
    parameter int PCNT_W      = 5,
    parameter int MAX_ACQ     = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sysref_in,
    input  logic [PER_W-1:0]  period_clks,
    input  logic              align_en,
    input  logic              sys_en,
    output logic              mf_strobe,
    output logic              aligned,
    output logic              acq_timeout,
    output logic [PCNT_W-1:0] pulse_cnt
);

    localparam int CNT_W = $clog2(PERIOD_MAX);
    localparam logic [PER_W-1:0] P_LO = PER_W'(PERIOD_MIN);
    localparam logic [PER_W-1:0] P_HI = PER_W'(PERIOD_MAX);

    logic             enable;
    logic [PER_W-1:0] period_eff;
    logic             sysref_ev;
    logic             realign;
    logic             wrap;

    always_comb begin
        enable = align_en & sys_en;
        if (period_clks < P_LO)
            period_eff = P_LO;
        else if (period_clks > P_HI)
            period_eff = P_HI;
        else
            period_eff = period_clks;
    end

    sra_sysref_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sysref_in (sysref_in),
        .event_o   (sysref_ev)
    );

    sra_mf_counter #(
        .PER_W (PER_W),
        .CNT_W (CNT_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .realign (realign),
        .period  (period_eff),
        .wrap_o  (wrap)
    );

    sra_align_fsm #(
        .PCNT_W  (PCNT_W),
        .MAX_ACQ (MAX_ACQ)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .sysref_ev   (sysref_ev),
        .on_boundary (wrap),
        .realign     (realign),
        .aligned     (aligned),
        .acq_timeout (acq_timeout),
        .pulse_cnt   (pulse_cnt)
    );

    assign mf_strobe = wrap;

    AST_PERIOD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (period_eff >= P_LO) && (period_eff <= P_HI)); // R3

endmodule

// File: tb/sysref_align_mon_bench.sv
module sysref_align_mon_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sysref = 1'b0;
    logic [10:0] period = 11'd8;
    logic        align_en = 1'b0;
    logic        sys_en = 1'b0;
    logic        strobe;
    logic        aligned;
    logic        tmo;
    logic [4:0]  pcnt;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    sysref_align_mon u_sysref_align_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .sysref_in   (sysref),
        .period_clks (period),
        .align_en    (align_en),
        .sys_en      (sys_en),
        .mf_strobe   (strobe),
        .aligned     (aligned),
        .acq_timeout (tmo),
        .pulse_cnt   (pcnt)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // pulse rising at the current negedge; next pulse starts gap clocks later
    task automatic send(int gap);
        sysref = 1'b1;
        tick(2);
        sysref = 1'b0;
        tick(gap - 2);
    endtask

    task automatic start_run(int p);
        align_en = 1'b0;
        sys_en   = 1'b0;
        period   = 11'(p);
        tick(2);
        align_en = 1'b1;
        sys_en   = 1'b1;
        tick(1);
    endtask

    task automatic measure(output int p);
        int c;
        c = 0;
        while (strobe == 1'b0 && c < 2100) begin tick(1); c++; end
        c = 0;
        do begin tick(1); c++; end while (strobe == 1'b0 && c < 2100);
        p = c;
    endtask

    task automatic report;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        int p;
        int cnt;
        int per_list[7] = '{4, 5, 6, 7, 9, 16, 33};
        int lat_list[5] = '{4, 5, 6, 8, 11};
        int clamp_in[4] = '{0, 3, 1500, 1024};
        int clamp_ex[4] = '{4, 4, 1024, 1024};

        // R1 reset state
        tick(3);
        chk("R1 strobe", strobe, 0);
        chk("R1 aligned", aligned, 0);
        chk("R1 timeout", tmo, 0);
        chk("R1 count", pcnt, 0);
        rst_n = 1'b1;
        tick(2);
        chk("R1 count after reset", pcnt, 0);

        // R2 one enable missing: pulses ignored, no strobe
        for (int k = 0; k < 2; k++) begin
            align_en = (k == 0) ? 1'b0 : 1'b1;
            sys_en   = (k == 0) ? 1'b1 : 1'b0;
            period = 11'd8;
            cnt = 0;
            for (int i = 0; i < 4; i++) begin
                sysref = 1'b1;
                for (int j = 0; j < 3; j++) begin tick(1); cnt += strobe; end
                sysref = 1'b0;
                for (int j = 0; j < 6; j++) begin tick(1); cnt += strobe; end
            end
            chk("R2 strobe count", cnt, 0);
            chk("R2 pulse count", pcnt, 0);
            chk("R2 aligned", aligned, 0);
        end

        // R3 period sweep and clamping
        foreach (per_list[i]) begin
            start_run(per_list[i]);
            measure(p);
            chk("R3 strobe spacing", p, per_list[i]);
        end
        foreach (clamp_in[i]) begin
            start_run(clamp_in[i]);
            measure(p);
            chk("R3 clamped spacing", p, clamp_ex[i]);
        end

        // R4 first pulse phase, R5 confirmation at 2P
        foreach (lat_list[i]) begin
            p = lat_list[i];
            start_run(p);
            sysref = 1'b1;
            tick(2);
            sysref = 1'b0;
            tick(p - 1);
            chk("R4 strobe before", strobe, 0);
            tick(1);
            chk("R4 strobe at phase", strobe, 1);
            tick(1);
            chk("R4 strobe after", strobe, 0);
            chk("R5 not yet aligned", aligned, 0);
            chk("R5 one pulse", pcnt, 1);
            tick(p - 3);
            send(p);
            chk("R5 aligned", aligned, 1);
            chk("R5 two pulses", pcnt, 2);
        end

        // R6 off-boundary confirm, then re-confirm; R7 loss and relock; R12 hold
        start_run(8);
        send(11);
        send(16);
        chk("R6 off boundary", aligned, 0);
        chk("R6 count", pcnt, 2);
        send(8);
        chk("R6 relocked", aligned, 1);
        send(9);
        chk("R12 holds", aligned, 1);
        send(8);
        chk("R7 lost", aligned, 0);
        send(24);
        chk("R7 relock", aligned, 1);
        send(8);
        chk("R12 multiple of P", aligned, 1);
        chk("R12 count", pcnt, 7);

        // R8 long pulse counted once
        start_run(8);
        sysref = 1'b1;
        tick(12);
        sysref = 1'b0;
        tick(3);
        chk("R8 long pulse", pcnt, 1);

        // R10 timeout after fifteen, continues; R9 saturation
        start_run(8);
        for (int i = 0; i < 14; i++) send(9);
        chk("R10 no timeout at 14", tmo, 0);
        chk("R10 count 14", pcnt, 14);
        send(8);
        chk("R10 timeout at 15", tmo, 1);
        chk("R10 not aligned", aligned, 0);
        send(8);
        chk("R10 late lock", aligned, 1);
        chk("R10 timeout kept", tmo, 1);
        for (int i = 0; i < 20; i++) send(8);
        chk("R9 saturates", pcnt, 31);
        chk("R12 stays aligned", aligned, 1);

        // R11 dropping an enable clears
        sys_en = 1'b0;
        tick(1);
        chk("R11 aligned cleared", aligned, 0);
        chk("R11 timeout cleared", tmo, 0);
        chk("R11 count cleared", pcnt, 0);
        chk("R11 strobe low", strobe, 0);
        start_run(8);
        send(8);
        send(8);
        chk("R11 relock", aligned, 1);
        align_en = 1'b0;
        tick(1);
        chk("R11 align_en clears", aligned, 0);
        chk("R11 align_en count", pcnt, 0);

        report();
    end

endmodule